// File: doc/BRIEF.md
# Request Queue Bank with In-Order Dispatch

This block keeps the request bookkeeping for one input module of a three-stage switch that has buffers in the first and third stages and none in the middle stage. For every output module it keeps a cell counter, which stands for the cells held in that output module's queue. For every pair of output module and central module it keeps a request counter. Beside each request counter it keeps the age of the head request, which is the number of slots that request has waited. The central-module schedulers read these ages as matching weights.

Arriving cells come from up to N input ports in each slot. The request for each cell goes to one of the M request queues of its output module, and a linear-feedback shift register picks which one. Each central module may grant one request in a slot. Each grant removes one request and one head cell. When several central modules grant the same output module, the cells leave in sequence: the lowest-index granting central module takes the head cell, the next one takes the cell behind it, and so on. The block reports, for each central module, which output module's cell it carries and how far that cell sits from the head. The cell memory and the schedulers are outside this block.

Top module: `rq_bank`

## Requirements
- R1: After reset, every request count, head age and cell count is zero, every dispatch output is zero, the error flag is low, and the register that picks the queue holds 8'h01.
- R2: Valid arrivals are handled in ascending port order. Each one takes the current value s of an 8-bit register, goes to the request queue (dest, s mod M), and then advances the register to {s[6:0], s[7]^s[5]^s[4]^s[3]}. Only valid arrivals advance the register.
- R3: A request queue holds at most 2^CW-1 requests. Arrivals beyond the free room at the start of the slot are dropped, and a dequeue in the same slot does not add room. A drop sets err_ovf, and err_ovf stays high until reset.
- R4: A queue's head age is 0 while the queue is empty, and 0 in the slot when a new request becomes head (the queue was empty, or it was dequeued and still holds requests). Otherwise it rises by one per slot and stops at 2^WW-1.
- R5: A grant valid on central module r for output module j removes exactly one request from queue (j, r) if that queue is non-empty. A grant to an empty queue changes no count and produces no dispatch.
- R6: vq_count[j] equals the accepted arrivals for output module j minus its dispatched cells. It therefore always equals the sum of that output module's M request counts.
- R7: For each dispatching central module r, disp_om holds the granted output module, and disp_off is the number of lower-index central modules that dispatch from the same output module in the same slot. disp_off = 0 means the head cell.
- R8: The dispatch outputs are registered. They appear in the cycle after the grant and last one cycle. Flat vectors are indexed by queue q = j*M + r, with field q at bits [q*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | N | Cell arrival on each input port |
| arr_dest | input | N*DW | Destination output module per port |
| grant_valid | input | M | Grant from each central module |
| grant_om | input | M*DW | Output module granted by each central module |
| rq_count | output | K*M*CW | Pending requests per queue |
| rq_age | output | K*M*WW | Head age per queue |
| vq_count | output | K*VW | Cells held per output module |
| disp_valid | output | M | Cell dispatched through each central module |
| disp_om | output | M*DW | Output module of the dispatched cell |
| disp_off | output | M*OW | Offset of that cell from the head |
| err_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench uses these corner cases:
- Several central modules grant the same output module in one slot. A design that orders them wrongly would hand out the same head offset twice, or give the head cell to a higher-index link.
- A grant arrives for an empty queue. A faulty design would let its count underflow, or report a cell that does not exist.
- Arrivals are forced past a queue's capacity. This shows whether the excess is dropped, whether the sticky flag is raised and kept, and whether a same-slot dequeue is wrongly counted as free room.
- A queue is held non-empty for more slots than the age field can count. This exposes an age that wraps to zero, and an age that fails to restart when the head changes.

// File: rtl/rq_pkg.sv
package rq_pkg;

    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

    // Kind of head-age update for one request queue in a slot
    typedef enum logic [1:0] {
        HD_IDLE = 2'd0,   // queue empty after the slot
        HD_NEW  = 2'd1,   // a fresh request became head
        HD_AGE  = 2'd2    // same head, one slot older
    } head_ev_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/rq_pick.sv
module rq_pick #(
    parameter int N  = 4,
    parameter int M  = 4,
    parameter int MW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    arr_valid,
    output logic [N*MW-1:0] pick_cm
);
    import rq_pkg::*;

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;

    always_comb begin
        logic [LFSR_W-1:0] s;
        logic [LFSR_W-1:0] md;
        s       = lfsr_q;
        pick_cm = '0;
        for (int p = 0; p < N; p++) begin
            md = s % LFSR_W'(M);
            pick_cm[p*MW +: MW] = md[MW-1:0];
            if (arr_valid[p]) s = lfsr_step(s);
        end
        lfsr_d = s;
    end

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_SEED;
        else     lfsr_q <= lfsr_d;
    end

endmodule

// File: rtl/rq_route.sv
module rq_route #(
    parameter int N  = 4,
    parameter int K  = 4,
    parameter int M  = 4,
    parameter int DW = 2,
    parameter int MW = 2,
    parameter int EW = 3
) (
    input  logic [N-1:0]      arr_valid,
    input  logic [N*DW-1:0]   arr_dest,
    input  logic [N*MW-1:0]   pick_cm,
    output logic [K*M*EW-1:0] want
);
    always_comb begin
        int j;
        int q;
        want = '0;
        for (int p = 0; p < N; p++) begin
            j = int'(arr_dest[p*DW +: DW]);
            q = j * M + int'(pick_cm[p*MW +: MW]);
            if (arr_valid[p] && j < K)
                want[q*EW +: EW] = want[q*EW +: EW] + EW'(1);
        end
    end

endmodule

// File: rtl/rq_order.sv
module rq_order #(
    parameter int K  = 4,
    parameter int M  = 4,
    parameter int DW = 2,
    parameter int OW = 2
) (
    input  logic [M-1:0]    grant_valid,
    input  logic [M*DW-1:0] grant_om,
    input  logic [K*M-1:0]  nonempty,
    output logic [M-1:0]    eff,
    output logic [K*M-1:0]  deq,
    output logic [M*OW-1:0] off
);
    always_comb begin
        int j;
        int cnt;
        eff = '0;
        deq = '0;
        off = '0;
        for (int r = 0; r < M; r++) begin
            j = int'(grant_om[r*DW +: DW]);
            if (grant_valid[r] && j < K) begin
                if (nonempty[j*M + r]) begin
                    eff[r] = 1'b1;
                    deq[j*M + r] = 1'b1;
                end
            end
        end
        for (int r = 0; r < M; r++) begin
            cnt = 0;
            for (int r2 = 0; r2 < r; r2++) begin
                if (eff[r2] && grant_om[r2*DW +: DW] == grant_om[r*DW +: DW])
                    cnt = cnt + 1;
            end
            if (eff[r]) off[r*OW +: OW] = OW'(cnt);
        end
    end

endmodule

// File: rtl/rq_slot.sv
module rq_slot #(
    parameter int CW = 3,
    parameter int EW = 3,
    parameter int WW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] want,
    input  logic          deq,
    output logic [CW-1:0] count,
    output logic [WW-1:0] age,
    output logic [EW-1:0] acc,
    output logic          drop
);
    import rq_pkg::*;

    localparam int CMAX = (1 << CW) - 1;
    localparam int WMAX = (1 << WW) - 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [WW-1:0] age_q, age_d;
    head_ev_e      ev;

    always_comb begin
        int room;
        room = CMAX - int'(cnt_q);
        if (int'(want) > room) begin
            acc  = EW'(room);
            drop = 1'b1;
        end else begin
            acc  = want;
            drop = 1'b0;
        end
        cnt_d = CW'(int'(cnt_q) - int'(deq) + int'(acc));

        if (cnt_d == '0)                ev = HD_IDLE;
        else if (cnt_q == '0 || deq)    ev = HD_NEW;
        else                            ev = HD_AGE;

        case (ev)
            HD_AGE:  age_d = (int'(age_q) == WMAX) ? age_q : age_q + WW'(1);
            default: age_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            age_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            age_q <= age_d;
        end
    end

    assign count = cnt_q;
    assign age   = age_q;

endmodule

// File: rtl/rq_bank.sv
module rq_bank #(
    parameter  int K  = 4,
    parameter  int M  = 4,
    parameter  int N  = 4,
    parameter  int CW = 3,
    parameter  int WW = 6,
    localparam int DW = (K > 1) ? $clog2(K) : 1,
    localparam int MW = (M > 1) ? $clog2(M) : 1,
    localparam int OW = MW,
    localparam int EW = $clog2(N + 1),
    localparam int VW = CW + ((M > 1) ? $clog2(M) : 0),
    localparam int NQ = K * M
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     arr_valid,
    input  logic [N*DW-1:0]  arr_dest,
    input  logic [M-1:0]     grant_valid,
    input  logic [M*DW-1:0]  grant_om,
    output logic [NQ*CW-1:0] rq_count,
    output logic [NQ*WW-1:0] rq_age,
    output logic [K*VW-1:0]  vq_count,
    output logic [M-1:0]     disp_valid,
    output logic [M*DW-1:0]  disp_om,
    output logic [M*OW-1:0]  disp_off,
    output logic             err_ovf
);
    logic [N*MW-1:0] pick_cm;
    logic [NQ*EW-1:0] want;
    logic [NQ*EW-1:0] acc;
    logic [NQ-1:0]    drop;
    logic [NQ-1:0]    nonempty;
    logic [NQ-1:0]    deq;
    logic [M-1:0]     eff;
    logic [M*OW-1:0]  off;
    logic [K*VW-1:0]  vq_q, vq_d;

    rq_pick #(.N(N), .M(M), .MW(MW)) u_pick (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .pick_cm(pick_cm)
    );

    rq_route #(.N(N), .K(K), .M(M), .DW(DW), .MW(MW), .EW(EW)) u_route (
        .arr_valid(arr_valid), .arr_dest(arr_dest), .pick_cm(pick_cm), .want(want)
    );

    rq_order #(.K(K), .M(M), .DW(DW), .OW(OW)) u_order (
        .grant_valid(grant_valid), .grant_om(grant_om), .nonempty(nonempty),
        .eff(eff), .deq(deq), .off(off)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        rq_slot #(.CW(CW), .EW(EW), .WW(WW)) u_slot (
            .clk(clk), .rst(rst),
            .want(want[q*EW +: EW]), .deq(deq[q]),
            .count(rq_count[q*CW +: CW]), .age(rq_age[q*WW +: WW]),
            .acc(acc[q*EW +: EW]), .drop(drop[q])
        );
        assign nonempty[q] = |rq_count[q*CW +: CW];
    end

    always_comb begin
        int s;
        for (int j = 0; j < K; j++) begin
            s = int'(vq_q[j*VW +: VW]);
            for (int r = 0; r < M; r++) begin
                s = s + int'(acc[(j*M + r)*EW +: EW]) - int'(deq[j*M + r]);
            end
            vq_d[j*VW +: VW] = VW'(s);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vq_q       <= '0;
            disp_valid <= '0;
            disp_om    <= '0;
            disp_off   <= '0;
            err_ovf    <= 1'b0;
        end else begin
            vq_q       <= vq_d;
            disp_valid <= eff;
            for (int r = 0; r < M; r++) begin
                disp_om[r*DW +: DW]  <= eff[r] ? grant_om[r*DW +: DW] : '0;
                disp_off[r*OW +: OW] <= off[r*OW +: OW];
            end
            err_ovf <= err_ovf | (|drop);
        end
    end

    assign vq_count = vq_q;

endmodule

// File: rtl/rq_bank_chk.sv
module rq_bank_chk #(
    parameter  int K  = 4,
    parameter  int M  = 4,
    parameter  int N  = 4,
    parameter  int CW = 3,
    parameter  int WW = 6,
    localparam int DW = (K > 1) ? $clog2(K) : 1,
    localparam int MW = (M > 1) ? $clog2(M) : 1,
    localparam int OW = MW,
    localparam int VW = CW + ((M > 1) ? $clog2(M) : 0),
    localparam int NQ = K * M
) (
    input logic             clk,
    input logic             rst,
    input logic [M-1:0]     grant_valid,
    input logic [NQ*CW-1:0] rq_count,
    input logic [NQ*WW-1:0] rq_age,
    input logic [K*VW-1:0]  vq_count,
    input logic [M-1:0]     disp_valid,
    input logic [M*OW-1:0]  disp_off,
    input logic             err_ovf
);
    logic [VW-1:0] rq_sum [K];

    always_comb begin
        int s;
        for (int j = 0; j < K; j++) begin
            s = 0;
            for (int r = 0; r < M; r++) s = s + int'(rq_count[(j*M + r)*CW +: CW]);
            rq_sum[j] = VW'(s);
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf); // R3

    for (genvar j = 0; j < K; j++) begin : g_vq
        AST_CELLS_MATCH: assert property (@(posedge clk) disable iff (rst)
            vq_count[j*VW +: VW] == rq_sum[j]); // R6
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        AST_AGE_IDLE: assert property (@(posedge clk) disable iff (rst)
            (rq_count[q*CW +: CW] == '0) |-> (rq_age[q*WW +: WW] == '0)); // R4
        AST_ONE_DEQ: assert property (@(posedge clk) disable iff (rst)
            int'(rq_count[q*CW +: CW]) + 1 >= int'($past(rq_count[q*CW +: CW]))); // R5
    end

    for (genvar r = 0; r < M; r++) begin : g_r
        AST_DISP_CAUSE: assert property (@(posedge clk) disable iff (rst)
            disp_valid[r] |-> $past(grant_valid[r])); // R8
        AST_OFF_BOUND: assert property (@(posedge clk) disable iff (rst)
            disp_valid[r] |-> (int'(disp_off[r*OW +: OW]) <= r)); // R7
    end

endmodule

bind rq_bank rq_bank_chk #(.K(K), .M(M), .N(N), .CW(CW), .WW(WW)) u_chk (
    .clk(clk), .rst(rst), .grant_valid(grant_valid),
    .rq_count(rq_count), .rq_age(rq_age), .vq_count(vq_count),
    .disp_valid(disp_valid), .disp_off(disp_off), .err_ovf(err_ovf)
);

// File: tb/rq_bank_tb.sv
module rq_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K = 4, M = 4, N = 4, CW = 3, WW = 6;
    localparam int DW = 2, OW = 2, VW = 5, NQ = K * M;
    localparam int CMAX = 7, WMAX = 63;
    localparam int NV = 16;

    // {arr_valid[3:0], arr_dest[7:0], grant_valid[3:0], grant_om[7:0]}
    localparam logic [23:0] VEC [NV] = '{
        24'hF1B000, 24'h305000, 24'h000FE4, 24'hFFF000,
        24'h000FFF, 24'h5AA350, 24'h000000, 24'h000000,
        24'hC00F00, 24'hF00F00, 24'h000AAA, 24'h81E6E1,
        24'h000000, 24'h2C49C6, 24'h000F55, 24'hF39F39
    };

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0]     arr_valid;
    logic [N*DW-1:0]  arr_dest;
    logic [M-1:0]     grant_valid;
    logic [M*DW-1:0]  grant_om;
    logic [NQ*CW-1:0] rq_count;
    logic [NQ*WW-1:0] rq_age;
    logic [K*VW-1:0]  vq_count;
    logic [M-1:0]     disp_valid;
    logic [M*DW-1:0]  disp_om;
    logic [M*OW-1:0]  disp_off;
    logic             err_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    rq_bank #(.K(K), .M(M), .N(N), .CW(CW), .WW(WW)) u_dut (.*);

    int total = 0, fails = 0;
    int m_cnt [NQ], m_age [NQ], m_vq [K];
    int e_dv [M], e_om [M], e_off [M];
    logic [7:0] m_lfsr;
    int m_err;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin m_cnt[q] = 0; m_age[q] = 0; end
        for (int j = 0; j < K; j++) m_vq[j] = 0;
        for (int r = 0; r < M; r++) begin e_dv[r] = 0; e_om[r] = 0; e_off[r] = 0; end
        m_lfsr = 8'h01;
        m_err = 0;
    endtask

    task automatic compare_all();
        for (int q = 0; q < NQ; q++) begin
            check(int'(rq_count[q*CW +: CW]) == m_cnt[q], "R2 R3 R5 count",
                  int'(rq_count[q*CW +: CW]), m_cnt[q]);
            check(int'(rq_age[q*WW +: WW]) == m_age[q], "R4 age",
                  int'(rq_age[q*WW +: WW]), m_age[q]);
        end
        for (int j = 0; j < K; j++)
            check(int'(vq_count[j*VW +: VW]) == m_vq[j], "R6 cells",
                  int'(vq_count[j*VW +: VW]), m_vq[j]);
        for (int r = 0; r < M; r++) begin
            check(int'(disp_valid[r]) == e_dv[r], "R5 R8 disp_valid", int'(disp_valid[r]), e_dv[r]);
            if (e_dv[r] != 0) begin
                check(int'(disp_om[r*DW +: DW]) == e_om[r], "R7 disp_om",
                      int'(disp_om[r*DW +: DW]), e_om[r]);
                check(int'(disp_off[r*OW +: OW]) == e_off[r], "R7 disp_off",
                      int'(disp_off[r*OW +: OW]), e_off[r]);
            end
        end
        check(int'(err_ovf) == m_err, "R3 err_ovf", int'(err_ovf), m_err);
    endtask

    task automatic slot(input logic [23:0] v);
        logic [3:0] av, gv;
        logic [7:0] ad, go;
        int want [NQ];
        int deq [NQ];
        int acc, room, nc, j, q;
        logic [7:0] s;
        {av, ad, gv, go} = v;
        @(negedge clk);
        arr_valid = av; arr_dest = ad; grant_valid = gv; grant_om = go;
        for (q = 0; q < NQ; q++) begin want[q] = 0; deq[q] = 0; end
        // grants act on the state at the start of the slot
        for (int r = 0; r < M; r++) begin
            j = int'(go[r*2 +: 2]);
            e_dv[r] = (gv[r] && m_cnt[j*M + r] > 0) ? 1 : 0;
            e_om[r] = j;
            e_off[r] = 0;
            if (e_dv[r] != 0) deq[j*M + r] = 1;
        end
        for (int r = 0; r < M; r++)
            for (int r2 = 0; r2 < r; r2++)
                if (e_dv[r2] != 0 && e_om[r2] == e_om[r]) e_off[r]++;
        // arrivals, ascending port order
        s = m_lfsr;
        for (int p = 0; p < N; p++) begin
            if (av[p]) begin
                want[int'(ad[p*2 +: 2]) * M + int'(s % 8'd4)]++;
                s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
            end
        end
        m_lfsr = s;
        for (q = 0; q < NQ; q++) begin
            room = CMAX - m_cnt[q];
            acc = want[q];
            if (acc > room) begin acc = room; m_err = 1; end
            nc = m_cnt[q] - deq[q] + acc;
            if (nc == 0) m_age[q] = 0;
            else if (m_cnt[q] == 0 || deq[q] != 0) m_age[q] = 0;
            else if (m_age[q] < WMAX) m_age[q]++;
            m_vq[q / M] += acc - deq[q];
            m_cnt[q] = nc;
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        arr_valid = '0; arr_dest = '0; grant_valid = '0; grant_om = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        compare_all(); // R1
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        arr_valid = '0; arr_dest = '0; grant_valid = '0; grant_om = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        compare_all(); // R1 reset state

        // table-driven slots: R2 placement, R4 age, R5 grants, R6 cells, R7 order, R8 timing
        for (int i = 0; i < NV; i++) slot(VEC[i]);

        // R4: hold queues non-empty past the age limit
        for (int i = 0; i < WMAX + 6; i++) slot(24'h000000);

        // R7: all four links grant OM1 in one slot, then idle to see dispatch clear (R8)
        slot(24'h000F55);
        slot(24'h000000);

        // R5: grants to OM0 after reset, when every queue is empty, must be ignored
        apply_reset();
        slot(24'h000F00);
        check(disp_valid == '0, "R5 empty grant", int'(disp_valid), 0);

        // R3: flood OM0 past capacity, with same-slot dequeues
        for (int i = 0; i < 10; i++) slot(24'hF00000);
        check(err_ovf == 1'b1, "R3 overflow flag", int'(err_ovf), 1);
        slot(24'hF00F00);
        for (int i = 0; i < 3; i++) slot(24'h000000);
        check(err_ovf == 1'b1, "R3 flag sticky", int'(err_ovf), 1);

        // R1: reset clears the flag and all state
        apply_reset();
        check(err_ovf == 1'b0, "R1 flag cleared", int'(err_ovf), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule